// File: doc/BRIEF.md
# I2C Operating Role Control

This block keeps the two control bits that place an I2C controller in one of four roles: slave receive, slave transmit, master receive or master transmit. The CPU writes and reads the two bits, and the serial engine reports events: a frame beginning, a frame's acknowledge bit completing, a start condition, the R/W bit of an address byte, and lost arbitration. The block outputs the resulting role to the shift engine every cycle.

CPU writes are filtered through the hardware rules. A change to the direction bit made while a frame is on the wire waits until that frame's acknowledge bit is done. Lost arbitration while mastering drops the block to slave receive. After that, the master bit can be set again only once software has read it back as 0. In slave receive with address format enabled, the R/W bit of the first address byte after a start picks the direction.

The design has three small state machines:
- **Transfer tracker.** `XF_IDLE`→`XF_FRAME` on frame start. `XF_FRAME`→`XF_IDLE` on acknowledge done when no new frame starts in the same cycle. Separately, the address phase goes `AP_NONE`→`AP_WAIT` on a start condition, and `AP_WAIT`→`AP_NONE` when the R/W bit is delivered.
- **Direction-bit deferral.** `TP_NONE`→`TP_HELD` on a write during a frame. `TP_HELD`→`TP_NONE` when the frame ends, on lost arbitration, on a hardware direction select, or on a write that applies at once.
- **Master gate.** `MG_FREE`→`MG_LOCKED` on lost arbitration. `MG_LOCKED`→`MG_ARMED` on a read that sees master = 0. `MG_ARMED`→`MG_FREE` when master is written to 1.

Top module: `i2c_role_ctrl`

## Requirements
- R1: After reset the role output and the read data are both 2'b00 (slave receive).
- R2: The role is encoded as {master, direction} on `role_o`, with bit 1 = master and bit 0 = direction: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit. `cpu_rd_data` always equals `role_o`.
- R3: A write made while no frame is in progress sets both bits to `cpu_wr_data` on the next clock. `cpu_wr_data` bit 1 is master and bit 0 is direction.
- R4: A write made during a frame (after a `frame_start` cycle, before its `ack_done`) applies the master bit on the next clock. The direction bit is held back until the cycle after `ack_done`.
- R5: Several held direction writes within one frame leave only the last one. A write in the same cycle as that frame's `ack_done` applies on the next clock.
- R6: `arb_lost` while master = 1 gives role 00 on the next clock. Any held direction write, and any write in that same cycle, is discarded.
- R7: After an arbitration-loss clear, writes of master = 1 are ignored until a read (`cpu_rd_en`) has returned master = 0. The next write of master = 1 after that read succeeds. A read and a write in the same cycle count the write as before the read.
- R8: In slave receive with `addr_fmt_en` = 1, the first `rw_valid` after `start_det` sets the direction bit to `rw_bit` on the next clock (1 = transmit, 0 = receive). A held direction write is discarded at that point.
- R9: `rw_valid` changes nothing when `addr_fmt_en` = 0, when the role is not slave receive, or when no `start_det` has come since the last `rw_valid`.
- R10: Reads return the effective bits, never a held direction value.
- R11: A write of master = 0 clears master on the next clock in every gate state. It does not unlock the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_data | input | 2 | Write data {master, direction} |
| cpu_rd_en | input | 1 | CPU register read strobe |
| cpu_rd_data | output | 2 | Read data {master, direction} |
| addr_fmt_en | input | 1 | Addressing format enabled |
| frame_start | input | 1 | Engine starts a frame |
| ack_done | input | 1 | Acknowledge bit of the current frame finished |
| start_det | input | 1 | Start condition detected |
| rw_valid | input | 1 | R/W bit of an address byte available |
| rw_bit | input | 1 | The R/W bit value |
| arb_lost | input | 1 | Bus arbitration lost |
| role_o | output | 2 | Current role to the shift engine |

## Verification
The assertions assume single-cycle event strobes, and that `ack_done` means something only while a frame is tracked. They also assume the engine never reports arbitration loss in the same cycle as an address R/W bit while in slave receive. The directed part of the stimulus builds each ordering in turn: held writes, writes in the acknowledge cycle, arbitration loss with a pending write, and reads and writes on the locked gate. A long pseudo-random stretch then drives every strobe freely, and a behavioural model compares the role every clock. Random strobes may overlap in any way, and the model defines each overlap from the priority order stated in the requirements.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;

    localparam int ROLE_W  = 2;
    localparam int MST_BIT = 1;
    localparam int TRS_BIT = 0;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_SLV_RX = 2'b00,
        ROLE_SLV_TX = 2'b01,
        ROLE_MST_RX = 2'b10,
        ROLE_MST_TX = 2'b11
    } role_e;

    typedef enum logic { XF_IDLE, XF_FRAME } xfer_e;
    typedef enum logic { AP_NONE, AP_WAIT } addr_ph_e;
    typedef enum logic { TP_NONE, TP_HELD } trs_pend_e;
    typedef enum logic [1:0] { MG_FREE, MG_LOCKED, MG_ARMED } mst_gate_e;

endpackage

// File: rtl/i2c_role_xfer.sv
module i2c_role_xfer
    import i2c_role_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic ack_done,
    input  logic start_det,
    input  logic rw_valid,
    output logic busy,
    output logic frame_end,
    output logic addr_wait
);

    xfer_e    xf_q, xf_d;
    addr_ph_e ap_q, ap_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xf_q <= XF_IDLE;
            ap_q <= AP_NONE;
        end else begin
            xf_q <= xf_d;
            ap_q <= ap_d;
        end
    end

    always_comb begin
        xf_d = xf_q;
        unique case (xf_q)
            XF_IDLE:  if (frame_start) xf_d = XF_FRAME;
            XF_FRAME: if (ack_done && !frame_start) xf_d = XF_IDLE;
            default:  xf_d = XF_IDLE;
        endcase
        ap_d = ap_q;
        unique case (ap_q)
            AP_NONE: if (start_det) ap_d = AP_WAIT;
            AP_WAIT: if (rw_valid && !start_det) ap_d = AP_NONE;
            default: ap_d = AP_NONE;
        endcase
    end

    always_comb begin
        busy      = (xf_q == XF_FRAME);
        frame_end = (xf_q == XF_FRAME) && ack_done;
        addr_wait = (ap_q == AP_WAIT);
    end

endmodule

// File: rtl/i2c_role_trs.sv
module i2c_role_trs
    import i2c_role_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic frame_end,
    input  logic arb_hit,
    input  logic auto_hit,
    input  logic auto_val,
    input  logic wr_en,
    input  logic wr_trs,
    output logic trs,
    output logic held
);

    trs_pend_e pend_q, pend_d;
    logic      pval_q, pval_d;
    logic      trs_q, trs_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= TP_NONE;
            pval_q <= 1'b0;
            trs_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            pval_q <= pval_d;
            trs_q  <= trs_d;
        end
    end

    always_comb begin
        pend_d = pend_q;
        pval_d = pval_q;
        trs_d  = trs_q;
        if (arb_hit) begin
            trs_d  = 1'b0;
            pend_d = TP_NONE;
        end else if (auto_hit) begin
            trs_d  = auto_val;
            pend_d = TP_NONE;
        end else if (wr_en && (!busy || frame_end)) begin
            trs_d  = wr_trs;
            pend_d = TP_NONE;
        end else if (wr_en) begin
            pend_d = TP_HELD;
            pval_d = wr_trs;
        end else begin
            unique case (pend_q)
                TP_NONE: ;
                TP_HELD: if (frame_end) begin
                    trs_d  = pval_q;
                    pend_d = TP_NONE;
                end
                default: pend_d = TP_NONE;
            endcase
        end
    end

    always_comb begin
        trs  = trs_q;
        held = (pend_q == TP_HELD);
    end

endmodule

// File: rtl/i2c_role_mst.sv
module i2c_role_mst
    import i2c_role_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arb_hit,
    input  logic wr_en,
    input  logic wr_mst,
    input  logic rd_en,
    output logic mst,
    output logic locked
);

    mst_gate_e gate_q, gate_d;
    logic      mst_q, mst_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= MG_FREE;
            mst_q  <= 1'b0;
        end else begin
            gate_q <= gate_d;
            mst_q  <= mst_d;
        end
    end

    always_comb begin
        gate_d = gate_q;
        mst_d  = mst_q;
        if (arb_hit) begin
            mst_d  = 1'b0;
            gate_d = MG_LOCKED;
        end else begin
            unique case (gate_q)
                MG_FREE: if (wr_en) mst_d = wr_mst;
                MG_LOCKED: begin
                    if (wr_en && !wr_mst) mst_d = 1'b0;
                    if (rd_en && !mst_q)  gate_d = MG_ARMED;
                end
                MG_ARMED: if (wr_en) begin
                    mst_d = wr_mst;
                    if (wr_mst) gate_d = MG_FREE;
                end
                default: gate_d = MG_FREE;
            endcase
        end
    end

    always_comb begin
        mst    = mst_q;
        locked = (gate_q == MG_LOCKED);
    end

endmodule

// File: rtl/i2c_role_ctrl.sv
module i2c_role_ctrl
    import i2c_role_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [ROLE_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_en,
    output logic [ROLE_W-1:0] cpu_rd_data,
    input  logic              addr_fmt_en,
    input  logic              frame_start,
    input  logic              ack_done,
    input  logic              start_det,
    input  logic              rw_valid,
    input  logic              rw_bit,
    input  logic              arb_lost,
    output logic [ROLE_W-1:0] role_o
);

    logic  busy, frame_end, addr_wait;
    logic  mst, trs, held, mst_locked;
    logic  arb_hit, auto_hit;
    role_e role;

    i2c_role_xfer u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .ack_done   (ack_done),
        .start_det  (start_det),
        .rw_valid   (rw_valid),
        .busy       (busy),
        .frame_end  (frame_end),
        .addr_wait  (addr_wait)
    );

    always_comb begin
        role     = role_e'({mst, trs});
        arb_hit  = arb_lost && mst;
        auto_hit = rw_valid && addr_wait && addr_fmt_en && (role == ROLE_SLV_RX);
    end

    i2c_role_mst u_mst (
        .clk   (clk),
        .rst_n (rst_n),
        .arb_hit(arb_hit),
        .wr_en (cpu_wr_en),
        .wr_mst(cpu_wr_data[MST_BIT]),
        .rd_en (cpu_rd_en),
        .mst   (mst),
        .locked(mst_locked)
    );

    i2c_role_trs u_trs (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .frame_end(frame_end),
        .arb_hit  (arb_hit),
        .auto_hit (auto_hit),
        .auto_val (rw_bit),
        .wr_en    (cpu_wr_en),
        .wr_trs   (cpu_wr_data[TRS_BIT]),
        .trs      (trs),
        .held     (held)
    );

    always_comb begin
        role_o      = role;
        cpu_rd_data = role;
    end

endmodule

// File: rtl/i2c_role_ctrl_chk.sv
module i2c_role_ctrl_chk
    import i2c_role_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr_en,
    input logic [ROLE_W-1:0] cpu_wr_data,
    input logic              addr_fmt_en,
    input logic              rw_valid,
    input logic              rw_bit,
    input logic              arb_lost,
    input logic [ROLE_W-1:0] role_o,
    input logic              busy,
    input logic              frame_end,
    input logic              addr_wait,
    input logic              mst_locked
);

    logic auto_ev, arb_ev;
    always_comb begin
        auto_ev = rw_valid && addr_wait && addr_fmt_en && (role_o == 2'b00);
        arb_ev  = arb_lost && role_o[MST_BIT];
    end

    p_arb_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arb_ev |=> (role_o == 2'b00));

    p_locked_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mst_locked |=> !role_o[MST_BIT]);

    p_held_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_end && cpu_wr_en && !arb_ev && !auto_ev)
        |=> (role_o[TRS_BIT] == $past(role_o[TRS_BIT])));

    p_idle_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && !busy && !arb_ev && !auto_ev)
        |=> (role_o[TRS_BIT] == $past(cpu_wr_data[TRS_BIT])));

    p_auto_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_ev |=> (role_o[TRS_BIT] == $past(rw_bit)));

    p_mst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && !cpu_wr_data[MST_BIT]) |=> !role_o[MST_BIT]);

endmodule

bind i2c_role_ctrl i2c_role_ctrl_chk u_chk (.*);

// File: tb/i2c_role_ctrl_bench.sv
module i2c_role_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 0, cpu_rd_en = 0;
    logic [1:0] cpu_wr_data = 0;
    logic [1:0] cpu_rd_data, role_o;
    logic       addr_fmt_en = 0, frame_start = 0, ack_done = 0;
    logic       start_det = 0, rw_valid = 0, rw_bit = 0, arb_lost = 0;

    int checks = 0, failures = 0;
    bit finished = 0;

    // behavioural reference state
    int m_mst, m_trs, m_busy, m_aw, m_pend, m_pval, m_gate; // gate: 0 free, 1 locked, 2 armed

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_role_ctrl u_i2c_role_ctrl (.*);

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [1:0] wd, input logic rd,
                       input logic fs, input logic ak, input logic ab,
                       input logic sd, input logic rv, input logic rb, input string tag);
        int arb, aut, fend;
        cpu_wr_en = wr; cpu_wr_data = wd; cpu_rd_en = rd;
        frame_start = fs; ack_done = ak; arb_lost = ab;
        start_det = sd; rw_valid = rv; rw_bit = rb;
        @(posedge clk);
        arb  = (ab && m_mst) ? 1 : 0;
        aut  = (rv && m_aw && addr_fmt_en && !m_mst && !m_trs) ? 1 : 0;
        fend = (m_busy && ak) ? 1 : 0;
        // direction bit
        if (arb) begin m_trs = 0; m_pend = 0; end
        else if (aut) begin m_trs = rb; m_pend = 0; end
        else if (wr && (!m_busy || fend)) begin m_trs = wd[0]; m_pend = 0; end
        else if (wr) begin m_pend = 1; m_pval = wd[0]; end
        else if (m_pend && fend) begin m_trs = m_pval; m_pend = 0; end
        // master bit and gate
        if (arb) begin m_mst = 0; m_gate = 1; end
        else if (m_gate == 0) begin if (wr) m_mst = wd[1]; end
        else if (m_gate == 1) begin
            if (wr && !wd[1]) m_mst = 0;
            if (rd) m_gate = 2;
        end else if (wr) begin
            m_mst = wd[1];
            if (wd[1]) m_gate = 0;
        end
        // transfer tracking
        if (!m_busy && fs) m_busy = 1;
        else if (m_busy && ak && !fs) m_busy = 0;
        if (!m_aw && sd) m_aw = 1;
        else if (m_aw && rv && !sd) m_aw = 0;
        @(negedge clk);
        check({tag, " R2 role"}, role_o, 2'(m_mst * 2 + m_trs));
        check({tag, " R10 readback"}, cpu_rd_data, 2'(m_mst * 2 + m_trs));
        cpu_wr_en = 0; cpu_rd_en = 0; frame_start = 0; ack_done = 0;
        arb_lost = 0; start_det = 0; rw_valid = 0;
    endtask

    task automatic wr(input logic [1:0] d, input string tag);
        cyc(1, d, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_mst = 0; m_trs = 0; m_busy = 0; m_aw = 0; m_pend = 0; m_pval = 0; m_gate = 0;
        repeat (3) @(negedge clk);
        check("R1 reset role", role_o, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", cpu_rd_data, 2'b00);

        // R3: idle writes apply next clock
        wr(2'b11, "R3"); check("R3 master tx", role_o, 2'b11);
        wr(2'b01, "R3"); check("R3 slave tx", role_o, 2'b01);
        wr(2'b10, "R3"); check("R3 master rx", role_o, 2'b10);
        wr(2'b00, "R3");

        // R4/R10: direction write deferred during a frame
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R4 start");
        wr(2'b11, "R4");
        check("R4 master now, direction held", role_o, 2'b10);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R10");
        check("R10 read shows effective", cpu_rd_data, 2'b10);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R4 ack");
        check("R4 applied after ack", role_o, 2'b11);

        // R5: last held write wins; write in ack cycle
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R5 start");
        wr(2'b10, "R5"); wr(2'b11, "R5"); wr(2'b10, "R5");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 ack");
        check("R5 last held write", role_o, 2'b10);
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R5 start2");
        cyc(1, 2'b11, 0, 0, 1, 0, 0, 0, 0, "R5 ack-cycle write");
        check("R5 write with ack", role_o, 2'b11);

        // R6: arbitration loss
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R6 start");
        wr(2'b10, "R6");
        cyc(1, 2'b11, 0, 0, 0, 1, 0, 0, 0, "R6 arb");
        check("R6 cleared", role_o, 2'b00);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R6 ack");
        check("R6 held write discarded", role_o, 2'b00);

        // R7/R11: master gate
        wr(2'b10, "R7"); check("R7 locked ignores set", role_o, 2'b00);
        wr(2'b00, "R11"); check("R11 clear while locked", role_o, 2'b00);
        wr(2'b10, "R11"); check("R11 still locked", role_o, 2'b00);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 read");
        wr(2'b10, "R7"); check("R7 set after read", role_o, 2'b10);
        wr(2'b00, "R11"); check("R11 clear", role_o, 2'b00);
        wr(2'b10, "R7"); check("R7 gate free", role_o, 2'b10);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R7 arb2");
        cyc(1, 2'b10, 1, 0, 0, 0, 0, 0, 0, "R7 read+write");
        check("R7 same-cycle write ignored", role_o, 2'b00);
        wr(2'b10, "R7"); check("R7 later write", role_o, 2'b10);
        wr(2'b00, "R3");

        // R8/R9: hardware direction from R/W bit
        addr_fmt_en = 1;
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8 start cond");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R8 frame");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, "R8 rw");
        check("R8 rw=1 selects transmit", role_o, 2'b01);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R8 ack");
        wr(2'b00, "R9");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R9 frame");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 no start");
        check("R9 second frame ignored", role_o, 2'b00);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R9 ack");
        wr(2'b01, "R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 start cond");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R9 not slave rx");
        check("R9 slave tx ignores rw", role_o, 2'b01);
        wr(2'b00, "R9");
        addr_fmt_en = 0;
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 start cond");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 fmt off");
        check("R9 format disabled", role_o, 2'b00);
        addr_fmt_en = 1;
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8 start cond");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R8 frame");
        wr(2'b01, "R8 held");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8 rw0");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R8 ack");
        check("R8 held write discarded", role_o, 2'b00);

        // free-running mixed stimulus against the model
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            addr_fmt_en = r[7];
            cyc(r[0] & r[1], 2'($urandom), r[2] & r[3], r[4], ($urandom % 3) == 0,
                ($urandom % 11) == 0, ($urandom % 5) == 0, r[5], r[6], "R2 mixed");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule